// File: doc/BRIEF.md
# Two-Drive PIO Strobe Sequencer

This block times one programmed-I/O transfer on a channel shared by two drives. When `start` is seen while the block is idle, it captures the timing that applies to the requested drive and direction. It then runs three phases in bus clocks: an address setup wait, an active strobe on either the read or the write line, and a recovery gap. The setup length is one value shared by both drives. The strobe and recovery lengths come from a per-bank, per-direction timing byte: the upper nibble gives the strobe width and the lower nibble gives the recovery width. Both are offset-encoded.

Four timing bytes are supplied as static configuration: a read byte and a write byte for bank A, and the same pair for bank B. A mapping input selects how the drives use the banks. When it is set, drive 0 uses bank A and drive 1 uses bank B. When it is clear, both drives use bank A. The data path and ready-line stretching are handled outside this block.

The state machine has four states. IDLE waits for `start`, and an accepted `start` moves it to SETUP. SETUP moves to ACTIVE when its count expires. ACTIVE moves to RECOVER when the strobe count expires. RECOVER returns to IDLE when the recovery count expires, and `done` is raised in that final cycle.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, `rd_strobe`, `wr_strobe`, `busy` and `done` are all low.
- R2: The setup phase lasts `setup_code + 1` clocks (1 to 4), whichever drive is selected. It begins in the clock after the edge that accepts `start`.
- R3: The active strobe lasts (bits [7:4] of the selected timing byte) + 1 clocks, from 1 to 16.
- R4: The recovery phase lasts (bits [3:0] of the selected timing byte) + 2 clocks, from 2 to 17.
- R5: A read (`wr_not_rd` = 0) uses the read byte and pulses only `rd_strobe`. A write (`wr_not_rd` = 1) uses the write byte and pulses only `wr_strobe`. The two strobes are never high together.
- R6: With `bank_split` = 1, drive 0 uses bank A and drive 1 uses bank B. With `bank_split` = 0, both drives use bank A.
- R7: The phases always run in the order setup, strobe, recovery. A strobe is high only in the active phase, and it is high without a gap.
- R8: `busy` is high in every clock from the one after acceptance through the last recovery clock. `done` is high for exactly one clock, which is the last clock of recovery. `busy` is low in the clock after that.
- R9: A `start` that arrives while `busy` is high is ignored. It does not lengthen or restart the transfer in progress.
- R10: The setup code, timing bytes, mapping, drive and direction are captured at acceptance. Changes to them during a transfer have no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a transfer (taken only when idle) |
| drive_sel | input | 1 | Target drive, 0 or 1 |
| wr_not_rd | input | 1 | 1 = write, 0 = read |
| bank_split | input | 1 | Drive-to-bank mapping control |
| setup_code | input | SETUP_W (2) | Shared setup length minus one |
| a_rd_timing | input | 2*NIB_W (8) | Bank A read: strobe-1 in upper nibble, recovery-2 in lower |
| a_wr_timing | input | 2*NIB_W (8) | Bank A write timing byte |
| b_rd_timing | input | 2*NIB_W (8) | Bank B read timing byte |
| b_wr_timing | input | 2*NIB_W (8) | Bank B write timing byte |
| rd_strobe | output | 1 | Read strobe, high during the active phase of a read |
| wr_strobe | output | 1 | Write strobe, high during the active phase of a write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last clock of recovery |

## Verification
The bench builds the block with its defaults, NIB_W = 4 and SETUP_W = 2. With these values every encodable length can be reached: setup from 1 to 4, strobe from 1 to 16 and recovery from 2 to 17. The longest transfer is therefore 37 clocks, which the bench runs directly, along with the all-zero minimum. Every drive, direction and mapping combination is exercised. Random runs poke `start` mid-transfer and rewrite the configuration mid-transfer, to show that captured values and the busy lockout hold across full-length phases.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_RECOVER = 2'd3
    } pio_state_e;

endpackage

// File: rtl/pio_bank_select.sv
module pio_bank_select #(
    parameter int NIB_W = 4
) (
    input  logic               drive_sel,
    input  logic               wr_not_rd,
    input  logic               bank_split,
    input  logic [2*NIB_W-1:0] a_rd_timing,
    input  logic [2*NIB_W-1:0] a_wr_timing,
    input  logic [2*NIB_W-1:0] b_rd_timing,
    input  logic [2*NIB_W-1:0] b_wr_timing,
    output logic [NIB_W-1:0]   pulse_code,
    output logic [NIB_W-1:0]   recov_code
);
    localparam int BYTE_W = 2 * NIB_W;

    logic [BYTE_W-1:0] bank_a;
    logic [BYTE_W-1:0] bank_b;
    logic [BYTE_W-1:0] chosen;
    logic              use_b;

    // R6: bank B is reached only by drive 1 when the split mapping is on
    assign use_b = bank_split & drive_sel;

    // R5: direction picks the byte inside each bank
    assign bank_a = wr_not_rd ? a_wr_timing : a_rd_timing;
    assign bank_b = wr_not_rd ? b_wr_timing : b_rd_timing;
    assign chosen = use_b ? bank_b : bank_a;

    assign pulse_code = chosen[BYTE_W-1:NIB_W];
    assign recov_code = chosen[NIB_W-1:0];

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_timing_pkg::*;
#(
    parameter int NIB_W   = 4,
    parameter int SETUP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               wr_not_rd,
    input  logic [SETUP_W-1:0] setup_code,
    input  logic [NIB_W-1:0]   pulse_code,
    input  logic [NIB_W-1:0]   recov_code,
    output logic               rd_strobe,
    output logic               wr_strobe,
    output logic               busy,
    output logic               done
);
    localparam int CNT_W = ((NIB_W + 1) > SETUP_W) ? (NIB_W + 1) : SETUP_W;

    pio_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [NIB_W-1:0] pulse_q;
    logic [NIB_W-1:0] recov_q;
    logic             dir_q;
    logic             accept;
    logic             cnt_zero;

    assign accept   = (state == ST_IDLE) && start;
    assign cnt_zero = (cnt == '0);

    // next-state and counter load
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt - CNT_W'(1);
        unique case (state)
            ST_IDLE: begin
                cnt_nx = cnt;
                if (start) begin
                    state_nx = ST_SETUP;
                    cnt_nx   = CNT_W'(setup_code);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_nx = ST_ACTIVE;
                    cnt_nx   = CNT_W'(pulse_q);
                end
            end
            ST_ACTIVE: begin
                if (cnt_zero) begin
                    state_nx = ST_RECOVER;
                    cnt_nx   = CNT_W'(recov_q) + CNT_W'(1);
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register, counter and captured timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            pulse_q <= '0;
            recov_q <= '0;
            dir_q   <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if (accept) begin
                pulse_q <= pulse_code;
                recov_q <= recov_code;
                dir_q   <= wr_not_rd;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        rd_strobe = 1'b0;
        wr_strobe = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_SETUP:   ;
            ST_ACTIVE: begin
                rd_strobe = ~dir_q;
                wr_strobe = dir_q;
            end
            ST_RECOVER: done = cnt_zero;
            default:    busy = 1'b0;
        endcase
    end

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));

    assert_setup_to_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_SETUP && state != ST_SETUP) |-> state == ST_ACTIVE);

    assert_active_to_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ACTIVE && state != ST_ACTIVE) |-> state == ST_RECOVER);

    assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_captured_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> ($stable(pulse_q) && $stable(recov_q) && $stable(dir_q)));

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer #(
    parameter int NIB_W   = 4,
    parameter int SETUP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               drive_sel,
    input  logic               wr_not_rd,
    input  logic               bank_split,
    input  logic [SETUP_W-1:0] setup_code,
    input  logic [2*NIB_W-1:0] a_rd_timing,
    input  logic [2*NIB_W-1:0] a_wr_timing,
    input  logic [2*NIB_W-1:0] b_rd_timing,
    input  logic [2*NIB_W-1:0] b_wr_timing,
    output logic               rd_strobe,
    output logic               wr_strobe,
    output logic               busy,
    output logic               done
);
    logic [NIB_W-1:0] pulse_code;
    logic [NIB_W-1:0] recov_code;

    pio_bank_select #(.NIB_W(NIB_W)) u_sel (
        .drive_sel  (drive_sel),
        .wr_not_rd  (wr_not_rd),
        .bank_split (bank_split),
        .a_rd_timing(a_rd_timing),
        .a_wr_timing(a_wr_timing),
        .b_rd_timing(b_rd_timing),
        .b_wr_timing(b_wr_timing),
        .pulse_code (pulse_code),
        .recov_code (recov_code)
    );

    pio_phase_fsm #(.NIB_W(NIB_W), .SETUP_W(SETUP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr_not_rd (wr_not_rd),
        .setup_code(setup_code),
        .pulse_code(pulse_code),
        .recov_code(recov_code),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: tb/sim_pio_cycle_timer.sv
module sim_pio_cycle_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       drive_sel = 1'b0;
    logic       wr_not_rd = 1'b0;
    logic       bank_split = 1'b1;
    logic [1:0] setup_code = 2'd0;
    logic [7:0] a_rd = 8'h00, a_wr = 8'h00, b_rd = 8'h00, b_wr = 8'h00;
    logic       rd_strobe, wr_strobe, busy, done;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pio_cycle_timer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .drive_sel(drive_sel),
        .wr_not_rd(wr_not_rd), .bank_split(bank_split), .setup_code(setup_code),
        .a_rd_timing(a_rd), .a_wr_timing(a_wr), .b_rd_timing(b_rd), .b_wr_timing(b_wr),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected timing byte from the mapping rules (R5, R6)
    function automatic logic [7:0] exp_byte(input logic drv, input logic wr, input logic split);
        if (split && drv) return wr ? b_wr : b_rd;
        return wr ? a_wr : a_rd;
    endfunction

    task automatic scramble();
        a_rd = 8'($urandom); a_wr = 8'($urandom);
        b_rd = 8'($urandom); b_wr = 8'($urandom);
        setup_code = 2'($urandom);
        bank_split = 1'($urandom);
        drive_sel = 1'($urandom);
        wr_not_rd = 1'($urandom);
    endtask

    task automatic run_xfer(input logic drv, input logic wr, input logic poke, input logic scr);
        logic [7:0] b;
        int es, ep, er;
        int s_n = 0, p_n = 0, r_n = 0, wrong = 0, gaps = 0, done_n = 0, done_at = -1, last = -1;
        bit seen = 0, ended = 0, in_p = 0;
        drive_sel = drv;
        wr_not_rd = wr;
        b  = exp_byte(drv, wr, bank_split);
        es = int'(setup_code) + 1;
        ep = int'(b[7:4]) + 1;
        er = int'(b[3:0]) + 2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 60; n++) begin
            if (!busy) begin ended = 1; break; end
            last = n;
            if (rd_strobe || wr_strobe) begin
                if (seen && !in_p) gaps++;
                seen = 1; in_p = 1; p_n++;
                if (wr ? rd_strobe : wr_strobe) wrong++;
            end else begin
                in_p = 0;
                if (!seen) s_n++; else r_n++;
            end
            if (done) begin done_n++; done_at = n; end
            if (poke && n == 1) start = 1'b1;
            if (poke && n == 2) start = 1'b0;
            if (scr && n == 1) scramble();
            @(negedge clk);
        end
        start = 1'b0;
        chk("R2 setup length", s_n, es);
        chk("R3 strobe length", p_n, ep);
        chk("R4 recovery length", r_n, er);
        chk("R5 wrong strobe kind", wrong, 0);
        chk("R7 strobe gaps", gaps, 0);
        chk("R8 done count", done_n, 1);
        chk("R8 done in last busy clock", done_at, last);
        chk("R9 busy ends after one transfer", int'(ended), 1);
        if (scr) chk("R10 captured values kept", s_n + p_n + r_n, es + ep + er);
        if (poke) chk("R9 poked start ignored", s_n + p_n + r_n, es + ep + er);
    endtask

    initial begin
        #(10 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1bad_5eed));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rd_strobe", int'(rd_strobe), 0);
        chk("R1 wr_strobe", int'(wr_strobe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // minimum lengths
        a_rd = 8'h00; a_wr = 8'h11; b_rd = 8'h22; b_wr = 8'h33;
        setup_code = 2'd0; bank_split = 1'b1;
        run_xfer(1'b0, 1'b0, 1'b0, 1'b0);
        // maximum lengths, write on bank B (R6 split mapping)
        b_wr = 8'hFF; setup_code = 2'd3;
        run_xfer(1'b1, 1'b1, 1'b0, 1'b0);
        // R6 drive 1 with mapping off uses bank A
        bank_split = 1'b0; a_rd = 8'h5A; b_rd = 8'h03; setup_code = 2'd1;
        run_xfer(1'b1, 1'b0, 1'b0, 1'b0);
        // R5 read vs write bytes differ in the same bank
        bank_split = 1'b1; b_rd = 8'h01; b_wr = 8'h9C; setup_code = 2'd2;
        run_xfer(1'b1, 1'b0, 1'b0, 1'b0);
        run_xfer(1'b1, 1'b1, 1'b0, 1'b0);
        // R9 start during busy, R10 config changed mid-transfer
        run_xfer(1'b0, 1'b1, 1'b1, 1'b1);

        for (int i = 0; i < 40; i++) begin
            scramble();
            run_xfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 3) == 0) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule